// File: doc/BRIEF.md
# Scan-Testable Two-Flop Sequence Detector

This block watches a serial input bit and raises its detect output once that bit has been 1 at two successive clock edges. The output stays high while the bit remains 1. Its state sits in two flip-flops. Each flip-flop has a two-way input selector in front of it. With the select low, the flops take the next state from a small two-level AND-OR network. With the select high, the two flops become a 2-bit shift chain. A tester can then place the machine in any state and read any state back over one serial input and one serial output.

A structural test walks every state-table transition in four steps:
- shift the source state into the chain (two clocks);
- observe the detect output;
- run one clock in normal mode with the chosen serial input;
- shift the destination state out (two clocks).

The next source state can be shifted in during the same two clocks that shift the destination out. Reset is synchronous so that it never blocks the scan path.

Top module: `scan_fsm_detector`

## Requirements
- R1: A synchronous reset (rst = 1 at a rising edge) puts the state at idle, encoded {y2,y1} = 00, and drives det = 0 and scan_out = 0. Reset takes priority over scan mode.
- R2: In normal mode (scan_en = 0), from idle (00) the machine stays in 00 when din = 0 and moves to 01 when din = 1.
- R3: In normal mode, from state 01 the machine moves to 00 when din = 0 and to 11 when din = 1.
- R4: In normal mode, from state 11 the machine stays in 11 when din = 1 and moves to 00 when din = 0.
- R5: det is a combinational function of the present state only. It is 1 exactly in state 11 and can be observed in both normal and scan mode.
- R6: From the unused code 10, the machine moves to 00 when din = 0 and to 01 when din = 1, and det is 0 while in 10.
- R7: In scan mode (scan_en = 1), each clock performs y1 <= scan_in and y2 <= y1. scan_out always shows y2. din has no effect in scan mode.
- R8: Two scan clocks load any state: first the y2 value is shifted in, then the y1 value. While loading, the two previous state bits leave on scan_out, y2 first and then y1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data bit under observation |
| scan_en | input | 1 | 1 = shift chain, 0 = normal operation |
| scan_in | input | 1 | Serial input to the head of the chain (y1) |
| det | output | 1 | Detect output, high in state 11 |
| scan_out | output | 1 | Serial output of the chain, equal to y2 |

## Verification
The bench builds the block with its default chain width of two, which is the only width the state encoding supports. With that width, every source state (including the unused code 10) can be loaded with two scan clocks, so all eight transitions of the state table, the unused-code recovery, reset priority over scan mode, and the fact that din is ignored during shifting can all be checked from the pins.

// File: rtl/scan_fsm_pkg.sv
package scan_fsm_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 2'b00,
    ST_ONE  = 2'b01,
    ST_BAD  = 2'b10,
    ST_HIT  = 2'b11
  } det_state_e;
endpackage

// File: rtl/scan_fsm_next.sv
module scan_fsm_next
  import scan_fsm_pkg::*;
(
  input  logic               din,
  input  logic [STATE_W-1:0] cur,
  output logic [STATE_W-1:0] nxt,
  output logic               det
);
  logic y1, y2;
  logic p0, p1, p2, p3;

  assign y1 = cur[0];
  assign y2 = cur[1];

  // two-level AND-OR network
  always_comb begin
    p0 = din & ~y1;
    p1 = din &  y1;
    p2 = din &  y1 & ~y2;
    p3 = din &  y1 &  y2;
    nxt[0] = p0 | p1;
    nxt[1] = p2 | p3;
    det    = y1 & y2;
  end
endmodule

// File: rtl/scan_fsm_cell.sv
module scan_fsm_cell (
  input  logic clk,
  input  logic rst,
  input  logic scan_en,
  input  logic d_func,
  input  logic d_scan,
  output logic q
);
  logic d_sel;

  assign d_sel = scan_en ? d_scan : d_func;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d_sel;
  end
endmodule

// File: rtl/scan_fsm_detector.sv
module scan_fsm_detector
  import scan_fsm_pkg::*;
#(
  parameter int CHAIN_W = STATE_W
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic scan_en,
  input  logic scan_in,
  output logic det,
  output logic scan_out
);
  localparam int LAST = CHAIN_W - 1;

  logic [CHAIN_W-1:0] state_q;
  logic [CHAIN_W-1:0] state_d;
  logic [CHAIN_W-1:0] shift_d;

  scan_fsm_next u_next (
    .din (din),
    .cur (state_q),
    .nxt (state_d),
    .det (det)
  );

  for (genvar i = 0; i < CHAIN_W; i++) begin : g_chain
    if (i == 0) begin : g_head
      assign shift_d[i] = scan_in;
    end else begin : g_body
      assign shift_d[i] = state_q[i-1];
    end
    scan_fsm_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .scan_en (scan_en),
      .d_func  (state_d[i]),
      .d_scan  (shift_d[i]),
      .q       (state_q[i])
    );
  end

  assign scan_out = state_q[LAST];

  // Assertions
  AST_SHIFT_HEAD: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> state_q[0] == $past(scan_in)); // R7
  AST_SHIFT_TAIL: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> scan_out == $past(state_q[0])); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && !din) |=> !det && !scan_out); // R2
  AST_HIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && din && det) |=> det); // R4
  AST_DET_ONLY_HIT: assert property (@(posedge clk) disable iff (rst)
    det |-> scan_out); // R5
endmodule

// File: tb/scan_fsm_detector_tb.sv
module scan_fsm_detector_tb;
  logic clk = 1'b0;
  logic rst, din, scan_en, scan_in;
  logic det, scan_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  scan_fsm_detector u_dut (
    .clk(clk), .rst(rst), .din(din), .scan_en(scan_en),
    .scan_in(scan_in), .det(det), .scan_out(scan_out)
  );

  // {src state, din, expected next, expected det in src, requirement number}
  typedef struct packed {
    logic [1:0] src;
    logic       w;
    logic [1:0] nxt;
    logic       z;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'b00, 1'b0, 2'b00, 1'b0, 4'd2},  // R2
    '{2'b00, 1'b1, 2'b01, 1'b0, 4'd2},  // R2
    '{2'b01, 1'b0, 2'b00, 1'b0, 4'd3},  // R3
    '{2'b01, 1'b1, 2'b11, 1'b0, 4'd3},  // R3
    '{2'b11, 1'b1, 2'b11, 1'b1, 4'd4},  // R4
    '{2'b11, 1'b0, 2'b00, 1'b1, 4'd4},  // R4
    '{2'b10, 1'b0, 2'b00, 1'b0, 4'd6},  // R6
    '{2'b10, 1'b1, 2'b01, 1'b0, 4'd6}   // R6
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // one clock; drive before the edge at negedge, sample at the next negedge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // load state s (y2 bit first); returns the two bits that left on scan_out
  task automatic load(input logic [1:0] s, output logic [1:0] old);
    scan_en = 1'b1;
    old[1] = scan_out;
    scan_in = s[1];
    tick();
    old[0] = scan_out;
    scan_in = s[0];
    tick();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] old;
    rst = 1'b1; din = 1'b0; scan_en = 1'b0; scan_in = 1'b0;
    @(negedge clk);
    tick();
    chk("R1 det after reset", det, 1'b0);
    chk("R1 scan_out after reset", scan_out, 1'b0);
    rst = 1'b0;

    // transition table walk
    for (int i = 0; i < 8; i++) begin
      load(VECS[i].src, old);
      chk($sformatf("R%0d det in source %b", VECS[i].req, VECS[i].src), det, VECS[i].z);
      chk($sformatf("R5 det in scan mode %b", VECS[i].src), det, VECS[i].src == 2'b11);
      scan_en = 1'b0;
      din = VECS[i].w;
      tick();
      chk($sformatf("R%0d y2 after %b w=%b", VECS[i].req, VECS[i].src, VECS[i].w), scan_out, VECS[i].nxt[1]);
      chk($sformatf("R5 det after %b w=%b", VECS[i].src, VECS[i].w), det, VECS[i].nxt == 2'b11);
      load(2'b00, old);
      chk($sformatf("R%0d y1 after %b w=%b", VECS[i].req, VECS[i].src, VECS[i].w), old[0], VECS[i].nxt[0]);
    end

    // R7: din ignored while shifting
    din = 1'b1;
    load(2'b01, old);
    din = 1'b0;
    load(2'b00, old);
    chk("R7 y2 with din toggling", old[1], 1'b0);
    chk("R7 y1 with din toggling", old[0], 1'b1);

    // R8: overlapped unload and load, bit order
    load(2'b10, old);
    load(2'b11, old);
    chk("R8 first bit out is y2", old[1], 1'b1);
    chk("R8 second bit out is y1", old[0], 1'b0);
    chk("R5 det after loading 11", det, 1'b1);

    // R1: reset wins over scan mode
    scan_en = 1'b1; scan_in = 1'b1; rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1 reset over scan det", det, 1'b0);
    load(2'b00, old);
    chk("R1 reset over scan y2", old[1], 1'b0);
    chk("R1 reset over scan y1", old[0], 1'b0);

    // normal run: din 1,1,1,0 from idle
    scan_en = 1'b0;
    din = 1'b1; tick();
    chk("R2 one ones no det", det, 1'b0);
    tick();
    chk("R3 two ones det", det, 1'b1);
    tick();
    chk("R4 three ones det held", det, 1'b1);
    din = 1'b0; tick();
    chk("R4 zero clears det", det, 1'b0);
    chk("R4 zero back to idle", scan_out, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule